// File: doc/BRIEF.md
# Aligned Memory Transaction Splitter

This block takes one memory access, given as a start byte address, a byte count and a read/write flag, and turns it into a stream of smaller transactions. Each transaction is legal for the memory path. A piece is 1 byte at any address, 2 bytes at an even address, or a whole number of 4-byte words at a 4-byte-aligned address. No piece is larger than the burst limit, and no piece runs past the end of a cacheline. The block carries only addresses and sizes. It moves no data and performs no cache lookup.

The block takes a command on a valid/ready input, and only while it is idle. It then produces one record on a valid/ready output for each handshake. Each record holds an address, a size in bytes, the read/write flag, and two flags that mark the first and the last piece of the command. At every step it picks the largest piece that the current alignment, the bytes left, the burst limit and the distance to the next line boundary allow. The burst limit (default 64 bytes) and the line size (default 128 bytes) are parameters.

Top module: `mem_xact_splitter`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. `in_ready` is 1 exactly when no command is in progress, and a command is taken on a clock edge where `in_valid` and `in_ready` are both 1.
- R2: A command whose `in_len` is 0 produces no output record, and `in_ready` stays 1 in the cycle after it is taken.
- R3: A record whose address is odd has `out_size` equal to 1.
- R4: A record with `out_size` equal to 2 has an even address. At an address that is 2 mod 4, with at least 2 bytes left, the size is 2.
- R5: A record with `out_size` of 4 or more has a size that is a multiple of 4 and an address that is a multiple of 4.
- R6: `out_size` is never 0 and never larger than BURST_BYTES (64).
- R7: The address offset within the line, plus `out_size`, is never more than LINE_BYTES (128), so no piece crosses a line boundary.
- R8: Each piece is the largest size that satisfies R3 to R7 and does not exceed the bytes left.
- R9: The first record starts at the command address. Each later record starts at the previous address plus the previous size, and the sizes add up to `in_len`.
- R10: `out_first` is 1 only on the first record of a command, and `out_last` is 1 only on its final record.
- R11: While `out_valid` is 1 and `out_ready` is 0, all output fields hold their values on the next cycle.
- R12: `out_wr` equals the `in_wr` value of the command being split.
- R13: With `out_ready` held at 1, a new record appears every cycle. The first record is visible in the cycle after the command is taken, and `in_ready` returns to 1 in the cycle after the last handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command is valid |
| in_ready | output | 1 | Splitter is idle and can take a command |
| in_addr | input | ADDR_W | Start byte address |
| in_len | input | LEN_W | Length in bytes |
| in_wr | input | 1 | 1 for a write, 0 for a read |
| out_valid | output | 1 | Record is valid |
| out_ready | input | 1 | Downstream takes the record |
| out_addr | output | ADDR_W | Record byte address |
| out_size | output | clog2(BURST_BYTES+1) | Record size in bytes |
| out_wr | output | 1 | Write flag of the command |
| out_first | output | 1 | Record is the first piece of the command |
| out_last | output | 1 | Record is the final piece of the command |

## Verification
A command taken at clock edge k shows its first record in the cycle after edge k. Each output handshake at an edge exposes the next record in the cycle that follows that edge. After the last handshake, `in_ready` rises one cycle later. The bench's behavioural model applies accepts and handshakes on the same edges the design uses. It then compares every output half a clock period later, so each expected value is checked in exactly the cycle it is due. Random backpressure stretches the hold periods, and a separate check confirms that a held record does not change.

// File: rtl/msplit_pkg.sv
package msplit_pkg;
   typedef enum logic {
      SPL_IDLE = 1'b0,
      SPL_BUSY = 1'b1
   } spl_state_e;
endpackage

// File: rtl/msplit_piece_calc.sv
module msplit_piece_calc #(
   parameter int LEN_W       = 16,
   parameter int LINE_BYTES  = 128,
   parameter int BURST_BYTES = 64,
   parameter int OFF_W       = $clog2(LINE_BYTES),
   parameter int SIZE_W      = $clog2(BURST_BYTES + 1)
) (
   input  logic [OFF_W-1:0]  line_off,
   input  logic [LEN_W-1:0]  rem,
   output logic [SIZE_W-1:0] piece_size,
   output logic              piece_last
);
   localparam int CW = ((LEN_W > OFF_W + 1) ? LEN_W : OFF_W + 1) + 1;

   logic [CW-1:0] rem_x;
   logic [CW-1:0] rem_words;
   logic [CW-1:0] line_room;
   logic [CW-1:0] cap_x;
   logic [CW-1:0] big_x;

   assign rem_x     = CW'(rem);
   assign rem_words = {rem_x[CW-1:2], 2'b00};
   assign line_room = CW'(LINE_BYTES) - CW'(line_off);

   generate
      if (BURST_BYTES == LINE_BYTES) begin : g_line_cap
         assign cap_x = line_room;
      end else begin : g_burst_cap
         assign cap_x = (line_room < CW'(BURST_BYTES)) ? line_room : CW'(BURST_BYTES);
      end
   endgenerate

   assign big_x = (rem_words < cap_x) ? rem_words : cap_x;

   always_comb begin
      if (line_off[0]) begin
         piece_size = SIZE_W'(1);
      end else if (line_off[1] || (rem_x < CW'(4))) begin
         piece_size = (rem_x >= CW'(2)) ? SIZE_W'(2) : SIZE_W'(1);
      end else begin
         piece_size = SIZE_W'(big_x);
      end
   end

   assign piece_last = (rem == LEN_W'(piece_size));
endmodule

// File: rtl/msplit_cursor.sv
module msplit_cursor
   import msplit_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int SIZE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_take,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic              cmd_wr,
   input  logic              step,
   input  logic [SIZE_W-1:0] step_size,
   input  logic              step_last,
   output logic              busy,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [LEN_W-1:0]  cur_rem,
   output logic              cur_first,
   output logic              cur_wr
);
   spl_state_e state_q;

   assign busy = (state_q == SPL_BUSY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SPL_IDLE;
         cur_addr  <= '0;
         cur_rem   <= '0;
         cur_first <= 1'b0;
         cur_wr    <= 1'b0;
      end else begin
         case (state_q)
            SPL_IDLE: begin
               if (cmd_take && (cmd_len != '0)) begin
                  state_q   <= SPL_BUSY;
                  cur_addr  <= cmd_addr;
                  cur_rem   <= cmd_len;
                  cur_first <= 1'b1;
                  cur_wr    <= cmd_wr;
               end
            end
            SPL_BUSY: begin
               if (step) begin
                  cur_addr  <= cur_addr + ADDR_W'(step_size);
                  cur_rem   <= cur_rem - LEN_W'(step_size);
                  cur_first <= 1'b0;
                  if (step_last) state_q <= SPL_IDLE;
               end
            end
            default: state_q <= SPL_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mem_xact_splitter.sv
module mem_xact_splitter #(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 16,
   parameter int LINE_BYTES  = 128,
   parameter int BURST_BYTES = 64
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               in_valid,
   output logic                               in_ready,
   input  logic [ADDR_W-1:0]                  in_addr,
   input  logic [LEN_W-1:0]                   in_len,
   input  logic                               in_wr,
   output logic                               out_valid,
   input  logic                               out_ready,
   output logic [ADDR_W-1:0]                  out_addr,
   output logic [$clog2(BURST_BYTES+1)-1:0]   out_size,
   output logic                               out_wr,
   output logic                               out_first,
   output logic                               out_last
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int SIZE_W = $clog2(BURST_BYTES + 1);

   initial begin
      assert (LINE_BYTES >= 4 && (1 << OFF_W) == LINE_BYTES)
         else $error("LINE_BYTES must be a power of two of at least 4");
      assert (BURST_BYTES >= 4 && BURST_BYTES % 4 == 0 && BURST_BYTES <= LINE_BYTES)
         else $error("BURST_BYTES must be a word multiple no larger than a line");
      assert (ADDR_W > OFF_W) else $error("ADDR_W too small for the line size");
      assert (LEN_W >= SIZE_W) else $error("LEN_W too small for the burst size");
   end

   logic              busy;
   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  cur_rem;
   logic              cur_first;
   logic              cur_wr;
   logic [SIZE_W-1:0] piece_size;
   logic              piece_last;
   logic              take;
   logic              step;

   assign in_ready = !busy;
   assign take     = in_valid && !busy;
   assign step     = busy && out_ready;

   msplit_cursor #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .SIZE_W (SIZE_W)
   ) u_cursor (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_take  (take),
      .cmd_addr  (in_addr),
      .cmd_len   (in_len),
      .cmd_wr    (in_wr),
      .step      (step),
      .step_size (piece_size),
      .step_last (piece_last),
      .busy      (busy),
      .cur_addr  (cur_addr),
      .cur_rem   (cur_rem),
      .cur_first (cur_first),
      .cur_wr    (cur_wr)
   );

   msplit_piece_calc #(
      .LEN_W       (LEN_W),
      .LINE_BYTES  (LINE_BYTES),
      .BURST_BYTES (BURST_BYTES),
      .OFF_W       (OFF_W),
      .SIZE_W      (SIZE_W)
   ) u_calc (
      .line_off   (cur_addr[OFF_W-1:0]),
      .rem        (cur_rem),
      .piece_size (piece_size),
      .piece_last (piece_last)
   );

   assign out_valid = busy;
   assign out_addr  = cur_addr;
   assign out_size  = piece_size;
   assign out_wr    = cur_wr;
   assign out_first = cur_first;
   assign out_last  = piece_last;
endmodule

// File: rtl/msplit_checker.sv
module msplit_checker #(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 16,
   parameter int LINE_BYTES  = 128,
   parameter int BURST_BYTES = 64,
   parameter int OFF_W       = $clog2(LINE_BYTES),
   parameter int SIZE_W      = $clog2(BURST_BYTES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [LEN_W-1:0]  in_len,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ADDR_W-1:0] out_addr,
   input logic [SIZE_W-1:0] out_size,
   input logic              out_first,
   input logic              out_last
);
   AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_len == '0) |=> (in_ready && !out_valid)); // R2
   AST_ODD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_addr[0]) |-> (out_size == SIZE_W'(1))); // R3
   AST_HALF_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_size == SIZE_W'(2)) |-> !out_addr[0]); // R4
   AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_size >= SIZE_W'(4)) |-> (out_size[1:0] == 2'b00 && out_addr[1:0] == 2'b00)); // R5
   AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_size != '0 && int'(out_size) <= BURST_BYTES)); // R6
   AST_NO_LINE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_addr[OFF_W-1:0]) + int'(out_size) <= LINE_BYTES)); // R7
   AST_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last) |=>
         (out_valid && !out_first && out_addr == $past(out_addr) + ADDR_W'($past(out_size)))); // R9
   AST_FIRST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_len != '0) |=> (out_valid && out_first)); // R10
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_addr) && $stable(out_size) && $stable(out_first) && $stable(out_last))); // R11
   AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> (in_ready && !out_valid)); // R13
endmodule

bind mem_xact_splitter msplit_checker #(
   .ADDR_W      (ADDR_W),
   .LEN_W       (LEN_W),
   .LINE_BYTES  (LINE_BYTES),
   .BURST_BYTES (BURST_BYTES)
) u_msplit_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_len    (in_len),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_addr  (out_addr),
   .out_size  (out_size),
   .out_first (out_first),
   .out_last  (out_last)
);

// File: tb/test_mem_xact_splitter.sv
module test_mem_xact_splitter;
   localparam int ADDR_W = 32;
   localparam int LEN_W  = 16;
   localparam int LINE   = 128;
   localparam int BURST  = 64;
   localparam int SW     = $clog2(BURST + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [ADDR_W-1:0] in_addr = '0;
   logic [LEN_W-1:0]  in_len = '0;
   logic              in_wr = 1'b0;
   logic              out_valid;
   logic              out_ready = 1'b1;
   logic [ADDR_W-1:0] out_addr;
   logic [SW-1:0]     out_size;
   logic              out_wr;
   logic              out_first;
   logic              out_last;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit backpressure = 1'b0;

   int q_addr[$];
   int q_size[$];
   bit q_first[$];
   bit q_last[$];
   bit exp_wr = 1'b0;

   bit held = 1'b0;
   int held_addr;
   int held_size;

   always #2.5 clk = ~clk;

   mem_xact_splitter #(
      .ADDR_W (ADDR_W), .LEN_W (LEN_W), .LINE_BYTES (LINE), .BURST_BYTES (BURST)
   ) i_mem_xact_splitter (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_ready (in_ready), .in_addr (in_addr),
      .in_len (in_len), .in_wr (in_wr),
      .out_valid (out_valid), .out_ready (out_ready), .out_addr (out_addr),
      .out_size (out_size), .out_wr (out_wr), .out_first (out_first), .out_last (out_last)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // Reference: try every size from the cap downward and keep the first legal one.
   function automatic void model_split(input int addr, input int len);
      int a = addr;
      int r = len;
      bit first = 1'b1;
      while (r > 0) begin
         int pick = 0;
         for (int s = BURST; s >= 1; s--) begin
            bit legal;
            legal = (s <= r) && ((a % LINE) + s <= LINE) &&
                    ((s == 1) || (s == 2 && a % 2 == 0) || (s >= 4 && s % 4 == 0 && a % 4 == 0));
            if (legal && pick == 0) pick = s;
         end
         q_addr.push_back(a);
         q_size.push_back(pick);
         q_first.push_back(first);
         q_last.push_back(pick == r);
         first = 1'b0;
         a += pick;
         r -= pick;
      end
   endfunction

   // Model update on the same edge the design uses.
   always @(posedge clk) begin
      cycles++;
      if (rst_n) begin
         held <= out_valid && !out_ready;
         held_addr <= int'(out_addr);
         held_size <= int'(out_size);
         if (q_addr.size() == 0 && in_valid) begin
            exp_wr = in_wr;
            model_split(int'(in_addr), int'(in_len));
         end else if (q_addr.size() != 0 && out_ready) begin
            void'(q_addr.pop_front());
            void'(q_size.pop_front());
            void'(q_first.pop_front());
            void'(q_last.pop_front());
         end
      end
   end

   // Comparison half a period after every edge.
   always @(negedge clk) begin
      if (rst_n) begin
         check(in_ready == (q_addr.size() == 0), "R1 in_ready", int'(in_ready), int'(q_addr.size() == 0));
         check(out_valid == (q_addr.size() != 0), "R13 out_valid", int'(out_valid), int'(q_addr.size() != 0));
         if (out_valid && q_addr.size() != 0) begin
            check(int'(out_addr) == q_addr[0], "R9 out_addr", int'(out_addr), q_addr[0]);
            check(int'(out_size) == q_size[0], "R8 out_size", int'(out_size), q_size[0]);
            check(out_first == q_first[0], "R10 out_first", int'(out_first), int'(q_first[0]));
            check(out_last == q_last[0], "R10 out_last", int'(out_last), int'(q_last[0]));
            check(out_wr == exp_wr, "R12 out_wr", int'(out_wr), int'(exp_wr));
            if (out_addr[0]) check(out_size == 1, "R3 odd size", int'(out_size), 1);
            if (out_size == 2) check(!out_addr[0], "R4 even addr", int'(out_addr[0]), 0);
            if (out_size >= 4)
               check(out_size % 4 == 0 && out_addr % 4 == 0, "R5 word align", int'(out_addr), int'(out_addr) & ~3);
            check(out_size != 0 && out_size <= BURST, "R6 size range", int'(out_size), BURST);
            check(int'(out_addr % LINE) + int'(out_size) <= LINE, "R7 line cross",
                  int'(out_addr % LINE) + int'(out_size), LINE);
         end
         if (held) begin
            check(out_valid && int'(out_addr) == held_addr && int'(out_size) == held_size,
                  "R11 hold", int'(out_addr), held_addr);
         end
      end
   end

   // Output backpressure driver.
   initial begin
      forever begin
         @(negedge clk);
         out_ready = backpressure ? ($urandom_range(0, 2) != 0) : 1'b1;
      end
   end

   task automatic send(input int addr, input int len, input bit wr);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_addr = ADDR_W'(addr);
      in_len = LEN_W'(len);
      in_wr = wr;
      @(negedge clk);
      in_valid = 1'b0;
      while (!in_ready) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!out_valid, "R1 reset out_valid", int'(out_valid), 0);
      check(in_ready, "R1 reset in_ready", int'(in_ready), 1);
      rst_n = 1'b1;

      send(0, 256, 1'b0);        // four full bursts
      send(3, 10, 1'b1);         // 1, 8, 1
      send(126, 8, 1'b0);        // 2, 4, 2 across a line edge
      send(112, 100, 1'b1);      // 16 to line end, 64, 20
      send(2, 1, 1'b0);          // single byte
      send(5, 3, 1'b1);          // 1, 2
      send(64, 0, 1'b1);         // zero length: R2
      check(in_ready && !out_valid, "R2 zero length", int'(out_valid), 0);
      send(1000, 65, 1'b0);

      backpressure = 1'b1;
      for (int k = 0; k < 300; k++) begin
         send(int'($urandom_range(0, 4095)), int'($urandom_range(0, 300)), bit'($urandom_range(0, 1)));
      end
      backpressure = 1'b0;
      for (int k = 0; k < 100; k++) begin
         send(int'($urandom_range(0, 4095)), int'($urandom_range(0, 40)), bit'($urandom_range(0, 1)));
      end

      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule